// File: doc/BRIEF.md
# Out-of-Order Completion Slot Ring

This block manages a ring of packet slots. Slots are handed out in order, dispatched in order, finished in any order, and retired strictly in order. Three free-running indices track the ring. The write index counts allocated slots, the dispatch index counts slots passed on for execution, and the read index counts retired slots.

A producer asks for a number of slots. It receives as many as are free, possibly fewer than it asked for, and it supplies a host base address for the batch. Each granted slot stores its own host address, which is the base plus its position in the batch times the packet size. The consumer sees the address of the slot at the dispatch index and strobes that index forward.

Finished slots are reported by slot number. The block keeps one completion bit per slot. Whenever a completion makes the slot at the read index finished, it retires the whole contiguous run of finished slots at once, and it reports that the read index moved.

Top module: `slot_retire_ring`

## Requirements
- R1: `alloc_grant_o` equals the smaller of `alloc_cnt_i` and `free_cnt_o` while `alloc_req_i` is high. It is 0 when no slot is free and 0 while `alloc_req_i` is low.
- R2: On the clock edge of a request, the write index advances by the granted count. The indices are free-running counters of log2(DEPTH)+1 bits that wrap modulo 2*DEPTH. `free_cnt_o` equals DEPTH minus (write index minus read index), computed modulo 2*DEPTH.
- R3: `disp_pend_o` is high exactly when the dispatch index differs from the write index. A `disp_adv_i` strobe advances the dispatch index by one only while a dispatch is pending. Otherwise the strobe is ignored and the index holds.
- R4: A completion on a slot whose distance from the read slot, taken modulo DEPTH, is below (dispatch index minus read index) sets that slot's completion bit. Slots may complete in any order, and a completion that does not reach the read slot leaves the read index unchanged.
- R5: On the edge of an accepted completion, the read index advances past the contiguous run of finished slots that starts at (read index mod DEPTH), and those bits are cleared. A run may span the whole ring.
- R6: `rd_moved_o` is high for exactly one cycle, the cycle after an accepted completion that advanced the read index. It is low otherwise.
- R7: A completion on a slot outside the dispatched window, or on a slot whose bit is already set, sets the sticky flag `cmpl_err_o` and leaves the indices and the bitmap unchanged.
- R8: Granted slot k of a batch (k counts from 0 at the write slot) stores `host_addr_i + k*PKT_BYTES`. `disp_addr_o` shows the stored address of slot (dispatch index mod DEPTH).
- R9: After reset, all indices are 0, `free_cnt_o` equals DEPTH, all completion bits are clear, and `disp_pend_o`, `rd_moved_o` and `cmpl_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_req_i | input | 1 | Allocation request |
| alloc_cnt_i | input | IDX_W | Number of slots requested |
| host_addr_i | input | ADDR_W | Host address of the first slot of the batch |
| alloc_grant_o | output | IDX_W | Number of slots granted this cycle |
| disp_adv_i | input | 1 | Dispatch-advance strobe |
| cmpl_vld_i | input | 1 | Completion strobe |
| cmpl_slot_i | input | SLOT_W | Slot number that finished |
| free_cnt_o | output | IDX_W | Number of free slots |
| wr_idx_o | output | IDX_W | Write index |
| disp_idx_o | output | IDX_W | Dispatch index |
| rd_idx_o | output | IDX_W | Read index |
| disp_pend_o | output | 1 | Slots are waiting for dispatch |
| disp_addr_o | output | ADDR_W | Host address of the slot at the dispatch index |
| rd_moved_o | output | 1 | Read index advanced on the last completion |
| cmpl_err_o | output | 1 | Sticky flag for an illegal completion |

## Verification
The ring is filled in several patterns:
- A small batch that fits.
- A request the ring can fill exactly.
- A request it can fill only in part.
- A request while it is full.

Together these separate correct clamping from grants that overshoot or underrun. Completions arrive in reverse order, so nothing retires until the oldest slot finishes. At that point a run of three slots, and later a run spanning all eight slots across the index wrap, must retire in one step. This distinguishes a scan of the run from single-step retirement. A duplicate completion followed by the missing one checks that an illegal report leaves state intact while legal retirement continues. Stored addresses are read back at every dispatch step across two batches and the wrap.

// File: rtl/slot_ring_pkg.sv
package slot_ring_pkg;

  function automatic int unsigned umin(int unsigned a, int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/slot_ring_alloc.sv
module slot_ring_alloc
  import slot_ring_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [IDX_W-1:0] cnt_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [IDX_W-1:0] grant_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [IDX_W-1:0] free_o
);
  localparam logic [IDX_W-1:0] DEPTH_V = IDX_W'(DEPTH);

  logic [IDX_W-1:0] wr_q;
  logic [IDX_W-1:0] used;

  assign used    = wr_q - rd_idx_i;
  assign free_o  = DEPTH_V - used;
  assign grant_o = req_i ? IDX_W'(umin(int'(cnt_i), int'(free_o))) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= '0;
    else         wr_q <= wr_q + grant_o;
  end

  assign wr_idx_o = wr_q;

  // R2
  used_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q - rd_idx_i) <= DEPTH_V);

endmodule

// File: rtl/slot_ring_retire.sv
module slot_ring_retire #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = $clog2(DEPTH) + 1,
  parameter int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmpl_vld_i,
  input  logic [SLOT_W-1:0] cmpl_slot_i,
  input  logic [IDX_W-1:0]  disp_idx_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              moved_o,
  output logic              err_o
);
  logic [IDX_W-1:0]  rd_q;
  logic [DEPTH-1:0]  map_q;
  logic              moved_q, err_q;

  logic [SLOT_W-1:0] rd_slot, ofs, p;
  logic [IDX_W-1:0]  outstanding, run;
  logic              in_win, dup, ok, bad, go;
  logic [DEPTH-1:0]  merged, nxt_map;

  assign rd_slot     = rd_q[SLOT_W-1:0];
  assign ofs         = cmpl_slot_i - rd_slot;
  assign outstanding = disp_idx_i - rd_q;
  assign in_win      = IDX_W'(ofs) < outstanding;
  assign dup         = map_q[cmpl_slot_i];
  assign ok          = cmpl_vld_i && in_win && !dup;
  assign bad         = cmpl_vld_i && !ok;

  // mark the new bit, then scan the finished run from the read slot
  always_comb begin
    merged = map_q;
    if (ok) merged[cmpl_slot_i] = 1'b1;
    nxt_map = merged;
    run     = '0;
    go      = 1'b1;
    p       = '0;
    for (int i = 0; i < DEPTH; i++) begin
      p = rd_slot + SLOT_W'(i);
      if (go && merged[p]) begin
        nxt_map[p] = 1'b0;
        run        = run + IDX_W'(1);
      end else begin
        go = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= '0;
      map_q   <= '0;
      moved_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (ok) begin
        map_q <= nxt_map;
        rd_q  <= rd_q + run;
      end
      moved_q <= ok && (run != '0);
      err_q   <= err_q | bad;
    end
  end

  assign rd_idx_o = rd_q;
  assign moved_o  = moved_q;
  assign err_o    = err_q;

  // R5
  head_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !map_q[rd_slot]);

  // R6
  moved_real_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    moved_q |-> (rd_q != $past(rd_q)));

  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

endmodule

// File: rtl/slot_ring_addr.sv
module slot_ring_addr #(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 32,
  parameter int PKT_BYTES = 64,
  parameter int IDX_W     = $clog2(DEPTH) + 1,
  parameter int SLOT_W    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  grant_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SLOT_W-1:0] disp_slot_i,
  output logic [ADDR_W-1:0] disp_addr_o
);
  logic [DEPTH-1:0][ADDR_W-1:0] addr_all;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic [SLOT_W-1:0] k;
    logic [ADDR_W-1:0] addr_q;
    logic              hit;

    assign k   = SLOT_W'(s) - wr_slot_i;
    assign hit = IDX_W'(k) < grant_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  addr_q <= '0;
      else if (hit) addr_q <= base_i + ADDR_W'(k) * ADDR_W'(PKT_BYTES);
    end

    assign addr_all[s] = addr_q;
  end

  assign disp_addr_o = addr_all[disp_slot_i];

endmodule

// File: rtl/slot_retire_ring.sv
module slot_retire_ring #(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 32,
  parameter int PKT_BYTES = 64,
  localparam int IDX_W    = $clog2(DEPTH) + 1,
  localparam int SLOT_W   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_req_i,
  input  logic [IDX_W-1:0]  alloc_cnt_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  output logic [IDX_W-1:0]  alloc_grant_o,
  input  logic              disp_adv_i,
  input  logic              cmpl_vld_i,
  input  logic [SLOT_W-1:0] cmpl_slot_i,
  output logic [IDX_W-1:0]  free_cnt_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [IDX_W-1:0]  disp_idx_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              disp_pend_o,
  output logic [ADDR_W-1:0] disp_addr_o,
  output logic              rd_moved_o,
  output logic              cmpl_err_o
);
  logic [IDX_W-1:0] wr_idx, rd_idx, grant;
  logic [IDX_W-1:0] disp_q;

  slot_ring_alloc #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_alloc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (alloc_req_i),
    .cnt_i    (alloc_cnt_i),
    .rd_idx_i (rd_idx),
    .grant_o  (grant),
    .wr_idx_o (wr_idx),
    .free_o   (free_cnt_o)
  );

  assign disp_pend_o = (disp_q != wr_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        disp_q <= '0;
    else if (disp_adv_i && disp_pend_o) disp_q <= disp_q + IDX_W'(1);
  end

  slot_ring_retire #(.DEPTH(DEPTH), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_retire (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmpl_vld_i  (cmpl_vld_i),
    .cmpl_slot_i (cmpl_slot_i),
    .disp_idx_i  (disp_q),
    .rd_idx_o    (rd_idx),
    .moved_o     (rd_moved_o),
    .err_o       (cmpl_err_o)
  );

  slot_ring_addr #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .PKT_BYTES(PKT_BYTES),
    .IDX_W(IDX_W), .SLOT_W(SLOT_W)
  ) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grant_i     (grant),
    .wr_slot_i   (wr_idx[SLOT_W-1:0]),
    .base_i      (host_addr_i),
    .disp_slot_i (disp_q[SLOT_W-1:0]),
    .disp_addr_o (disp_addr_o)
  );

  assign alloc_grant_o = grant;
  assign wr_idx_o      = wr_idx;
  assign rd_idx_o      = rd_idx;
  assign disp_idx_o    = disp_q;

  // R3
  disp_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_q - rd_idx) <= (wr_idx - rd_idx));

  // R3
  disp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_adv_i |=> $stable(disp_q));

endmodule

// File: tb/slot_retire_ring_tb_top.sv
module slot_retire_ring_tb_top;
  localparam int DEPTH = 8;
  localparam int IDX_W = 4;
  localparam int SLOT_W = 3;
  localparam int ADDR_W = 32;
  localparam int PKT = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic              alloc_req, disp_adv, cmpl_vld;
  logic [IDX_W-1:0]  alloc_cnt;
  logic [ADDR_W-1:0] host_addr;
  logic [SLOT_W-1:0] cmpl_slot;
  logic [IDX_W-1:0]  grant, free_cnt, wr_idx, disp_idx, rd_idx;
  logic              disp_pend, rd_moved, cmpl_err;
  logic [ADDR_W-1:0] disp_addr;

  slot_retire_ring #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PKT_BYTES(PKT)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_req_i(alloc_req), .alloc_cnt_i(alloc_cnt), .host_addr_i(host_addr),
    .alloc_grant_o(grant), .disp_adv_i(disp_adv),
    .cmpl_vld_i(cmpl_vld), .cmpl_slot_i(cmpl_slot),
    .free_cnt_o(free_cnt), .wr_idx_o(wr_idx), .disp_idx_o(disp_idx),
    .rd_idx_o(rd_idx), .disp_pend_o(disp_pend), .disp_addr_o(disp_addr),
    .rd_moved_o(rd_moved), .cmpl_err_o(cmpl_err)
  );

  int errs = 0, checks = 0;
  int exp_wr = 0, exp_rd = 0, exp_disp = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_free();
    return DEPTH - ((exp_wr - exp_rd + 16) % 16);
  endfunction

  task automatic do_alloc(input int n, input logic [31:0] base, input int exp_g);
    @(negedge clk);
    alloc_req = 1'b1; alloc_cnt = IDX_W'(n); host_addr = base;
    #1 chk("R1 grant", 32'(grant), 32'(exp_g));
    @(negedge clk);
    alloc_req = 1'b0;
    exp_wr = (exp_wr + exp_g) % 16;
    chk("R2 wr_idx", 32'(wr_idx), 32'(exp_wr));
    chk("R2 free_cnt", 32'(free_cnt), 32'(exp_free()));
  endtask

  task automatic do_dispatch(input logic [31:0] exp_addr, input bit exp_pend);
    @(negedge clk);
    chk("R3 disp_pend", 32'(disp_pend), 32'(exp_pend));
    if (exp_pend) chk("R8 disp_addr", disp_addr, exp_addr);
    disp_adv = 1'b1;
    @(negedge clk);
    disp_adv = 1'b0;
    if (exp_pend) exp_disp = (exp_disp + 1) % 16;
    chk("R3 disp_idx", 32'(disp_idx), 32'(exp_disp));
  endtask

  task automatic do_complete(input int slot, input int new_rd, input bit exp_moved, input string tag);
    @(negedge clk);
    cmpl_vld = 1'b1; cmpl_slot = SLOT_W'(slot);
    @(negedge clk);
    cmpl_vld = 1'b0;
    exp_rd = new_rd;
    chk({tag, " rd_idx"}, 32'(rd_idx), 32'(exp_rd));
    chk("R6 rd_moved", 32'(rd_moved), 32'(exp_moved));
    chk("R2 free_cnt", 32'(free_cnt), 32'(exp_free()));
  endtask

  task automatic t_reset();
    // R9
    chk("R9 rd_idx", 32'(rd_idx), 0);
    chk("R9 wr_idx", 32'(wr_idx), 0);
    chk("R9 disp_idx", 32'(disp_idx), 0);
    chk("R9 free_cnt", 32'(free_cnt), DEPTH);
    chk("R9 disp_pend", 32'(disp_pend), 0);
    chk("R9 rd_moved", 32'(rd_moved), 0);
    chk("R9 cmpl_err", 32'(cmpl_err), 0);
  endtask

  task automatic t_small_batch();
    do_alloc(3, 32'h1000, 3);
    for (int k = 0; k < 3; k++) do_dispatch(32'h1000 + 32'(k * PKT), 1'b1);
    do_dispatch(32'h0, 1'b0);  // R3 strobe ignored when nothing pending
  endtask

  task automatic t_reverse_retire();
    do_complete(2, 0, 1'b0, "R4");
    do_complete(1, 0, 1'b0, "R4");
    do_complete(0, 3, 1'b1, "R5");
    @(negedge clk);
    chk("R6 rd_moved single pulse", 32'(rd_moved), 0);
  endtask

  task automatic t_partial_grant();
    @(negedge clk);
    alloc_req = 1'b0; alloc_cnt = 4'd5;
    #1 chk("R1 grant without req", 32'(grant), 0);
    do_alloc(6, 32'h3000, 6);
    do_alloc(5, 32'h2000, 2);
    do_alloc(1, 32'h5000, 0);
    for (int k = 0; k < 6; k++) do_dispatch(32'h3000 + 32'(k * PKT), 1'b1);
    for (int k = 0; k < 2; k++) do_dispatch(32'h2000 + 32'(k * PKT), 1'b1);
  endtask

  task automatic t_full_run();
    // out-of-order completions for indices 10..4, then 3 retires all 8 (wraps to 11)
    for (int idx = 10; idx >= 4; idx--) do_complete(idx % DEPTH, 3, 1'b0, "R4");
    do_complete(3, 11, 1'b1, "R5");
  endtask

  task automatic t_dup_error();
    chk("R7 no error yet", 32'(cmpl_err), 0);
    do_alloc(2, 32'h7000, 2);
    do_dispatch(32'h7000, 1'b1);
    do_dispatch(32'h7040, 1'b1);
    do_complete(4, 11, 1'b0, "R4");
    do_complete(4, 11, 1'b0, "R7");  // duplicate: no state change
    chk("R7 cmpl_err set", 32'(cmpl_err), 1);
    do_complete(3, 13, 1'b1, "R5");  // legal retire still works, run of 2
    chk("R7 cmpl_err sticky", 32'(cmpl_err), 1);
  endtask

  initial begin
    alloc_req = 0; alloc_cnt = '0; host_addr = '0;
    disp_adv = 0; cmpl_vld = 0; cmpl_slot = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_small_batch();
    t_reverse_retire();
    t_partial_grant();
    t_full_run();
    t_dup_error();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule